// File: doc/BRIEF.md
# Window Watchdog with Deferred Clear

This block supervises a controller with a window watchdog. Software sets an enable bit through a register write, after which a counter advances by one on every tick pulse while the device is in its running mode. Each watchdog period is split into a closed phase and an open phase that follows it. Software must request a counter clear during the open phase. The request does not act when the register is written. It is held as pending until the chip-select line rises at the end of the serial transfer, and it is judged at that moment.

A clear that lands in the open phase restarts the period. A clear that lands in the closed phase triggers a watchdog reset pulse. So does an open phase that expires with no valid clear. The pulse disarms the block and zeroes its counter. Once armed, the block cannot be disarmed by software. Only a device reset or its own reset pulse disarms it.

Top module: `window_watchdog`

## Requirements
- R1: After reset the block is disarmed, `wd_rst` is low, `win_open` is low and `ctl_rdata` is all zero.
- R2: A write (`wr_en` high) with `wr_data[0]`=1 arms the block. `ctl_rdata[0]` reads the armed state.
- R3: A write with `wr_data[0]`=0 never disarms an armed block.
- R4: While disarmed, the counter stays at zero and clear requests (`wr_data[1]`=1) are ignored. No reset pulse is produced.
- R5: The counter advances only when `mode`=2'b00 (running). With `mode`=2'b01 (stop) or 2'b10 (sleep), it holds its value.
- R6: `win_open` goes high after CLOSED_TICKS counted ticks from a period start. It stays high for OPEN_TICKS ticks.
- R7: A clear request changes nothing at the write. It takes effect on the next rising edge of `ss_n`.
- R8: A pending clear judged during the open phase restarts the counter at zero, in the closed phase, with no reset pulse.
- R9: A pending clear judged during the closed phase causes a reset pulse.
- R10: If the open phase expires with no valid clear, a reset pulse is produced.
- R11: The reset pulse lasts exactly RST_PULSE cycles, and it leaves the block disarmed with the counter at zero.
- R12: The clear bit reads back as 0. Several clear writes within one `ss_n` low period merge into one request, which is consumed at the `ss_n` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | DATA_W | Write data: bit 0 arm, bit 1 clear request |
| ss_n | input | 1 | Serial chip select, active low; rising edge ends a transfer |
| mode | input | 2 | 00 running, 01 stop, 10 sleep |
| tick | input | 1 | Count enable pulse |
| wd_rst | output | 1 | Watchdog reset pulse |
| armed | output | 1 | Enable state |
| win_open | output | 1 | High during the open phase |
| ctl_rdata | output | DATA_W | Control register readback |

## Verification
Clear requests are placed at several points: before arming, early in the closed phase, in the open phase, and repeated within one transfer. Together these separate acting at the write from acting at the chip-select rise, and they show whether the phase is judged correctly. Counting is tried across stop and sleep intervals to show the count is held rather than reset. Free-running expiry shows whether the period length is exact. Each pulse is measured cycle by cycle for its length and its disarming effect.

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int CLOSED_TICKS = 4,
  parameter int OPEN_TICKS   = 4,
  parameter int RST_PULSE    = 3,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ss_n,
  input  logic [1:0]        mode,
  input  logic              tick,
  output logic              wd_rst,
  output logic              armed,
  output logic              win_open,
  output logic [DATA_W-1:0] ctl_rdata
);
  localparam int TOTAL = CLOSED_TICKS + OPEN_TICKS;
  localparam int CNT_W = (TOTAL > 2) ? $clog2(TOTAL) : 1;
  localparam int PW    = $clog2(RST_PULSE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] OPEN_AT = CNT_W'(CLOSED_TICKS);

  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pulse;
  logic             pend, ss_q;

  wire running = armed && (mode == 2'b00);
  wire ss_rise = ss_n && !ss_q;
  wire kick_wr = wr_en && wr_data[1] && armed;
  wire good    = ss_rise && pend && win_open;
  wire bad     = ss_rise && pend && !win_open;
  wire timeout = running && tick && (cnt == LAST) && !good;
  wire fire    = bad || timeout;

  assign win_open  = armed && (cnt >= OPEN_AT);
  assign wd_rst    = (pulse != '0);
  assign ctl_rdata = {{(DATA_W-1){1'b0}}, armed};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= '0;
      pend  <= 1'b0;
      armed <= 1'b0;
      ss_q  <= 1'b1;
    end else begin
      ss_q <= ss_n;
      if (fire) begin
        armed <= 1'b0;
        cnt   <= '0;
        pend  <= 1'b0;
        pulse <= PW'(RST_PULSE);
      end else begin
        if (pulse != '0) pulse <= pulse - 1'b1;
        if (wr_en && wr_data[0] && !wd_rst) armed <= 1'b1;
        if (good) cnt <= '0;
        else if (running && tick) cnt <= cnt + 1'b1;
        pend <= ss_rise ? 1'b0 : (pend | kick_wr);
      end
    end
  end

  assert_no_disarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !fire |=> armed);
  assert_disarmed_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> cnt == '0 && !pend);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b00 && !ss_rise |=> $stable(cnt));
  assert_write_defers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_rise && !tick |=> $stable(cnt));
  assert_closed_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_rise && pend && !win_open |=> wd_rst);
  assert_pulse_disarms_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst) |-> !armed && cnt == '0);
endmodule

// File: tb/tb_window_watchdog.sv
module tb_window_watchdog;
  logic clk = 0, rst_n = 0, wr_en = 0, ss_n = 1, tick = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] mode = 0;
  logic wd_rst, armed, win_open;
  logic [7:0] ctl_rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  window_watchdog #(.CLOSED_TICKS(4), .OPEN_TICKS(4), .RST_PULSE(3), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ss_n(ss_n),
    .mode(mode), .tick(tick), .wd_rst(wd_rst), .armed(armed),
    .win_open(win_open), .ctl_rdata(ctl_rdata));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0; ss_n = 1; tick = 0; mode = 0;
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d; @(negedge clk); wr_en = 0;
  endtask

  task automatic ss_lo(); @(negedge clk); ss_n = 0; endtask
  task automatic ss_hi(); @(negedge clk); ss_n = 1; @(negedge clk); endtask

  task automatic pulse_len(output int n);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (wd_rst) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 armed", armed, 0);
    chk("R1 wd_rst", wd_rst, 0);
    chk("R1 win_open", win_open, 0);
    chk("R1 rdata", ctl_rdata, 0);
  endtask

  task automatic t_disabled();
    do_reset();
    tk(20);
    chk("R4 no pulse when disarmed", wd_rst, 0);
    chk("R4 window closed", win_open, 0);
    ss_lo(); wr(8'h02); ss_hi();
    chk("R4 clear ignored", wd_rst, 0);
    wr(8'h01);
    chk("R2 armed", armed, 1);
    chk("R2 rdata", ctl_rdata[0], 1);
    tk(3);
    chk("R4 counter was zero", win_open, 0);
    tk(1);
    chk("R6 opens after closed phase", win_open, 1);
    wr(8'h00);
    chk("R3 stays armed", armed, 1);
  endtask

  task automatic t_modes();
    do_reset(); wr(8'h01);
    tk(2);
    mode = 2'b01; tk(10);
    chk("R5 stop holds", win_open, 0);
    chk("R5 stop no pulse", wd_rst, 0);
    mode = 2'b10; tk(10);
    chk("R5 sleep holds", win_open + 2 * wd_rst, 0);
    mode = 2'b00; tk(1);
    chk("R5 resumes count 3", win_open, 0);
    tk(1);
    chk("R5 resumes count 4 open", win_open, 1);
  endtask

  task automatic t_early();
    int n;
    do_reset(); wr(8'h01); tk(1);
    ss_lo(); wr(8'h02);
    chk("R7 no pulse at write", wd_rst, 0);
    chk("R12 clear reads 0", ctl_rdata[1], 0);
    ss_hi();
    pulse_len(n);
    chk("R9 closed clear pulse length R11", n, 3);
    chk("R11 disarmed after pulse", armed, 0);
  endtask

  task automatic t_valid();
    int n;
    do_reset(); wr(8'h01); tk(5);
    chk("R6 open at 5", win_open, 1);
    ss_lo(); wr(8'h02); wr(8'h02);
    chk("R12 clear reads 0", ctl_rdata[1], 0);
    tk(1);
    chk("R7 no restart at write", win_open, 1);
    ss_hi();
    chk("R8 restart closes window", win_open, 0);
    chk("R8 no pulse", wd_rst, 0);
    ss_lo(); ss_hi();
    chk("R12 request consumed once", wd_rst, 0);
    tk(3);
    chk("R8 restarted at zero", win_open, 0);
    tk(1);
    chk("R8 open after 4", win_open, 1);
    tk(3);
    chk("R6 still open at 7", win_open + 2 * wd_rst, 1);
    tk(1);
    pulse_len(n);
    chk("R10 timeout pulse length R11", n, 3);
    chk("R11 disarmed", armed, 0);
    tk(9);
    chk("R11 no further pulse", wd_rst, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_disabled();
    t_modes();
    t_early();
    t_valid();
    finish_run();
  end
endmodule